// File: doc/BRIEF.md
# Touch Contact Resistance Calculator

This block turns raw resistive-panel readings into an estimate of the resistance of the touch contact itself, which a host uses to tell a firm press from a light brush. It takes four 12-bit codes (X position, Y position and the two cross-panel readings Z1 and Z2), together with the plate resistances of the panel. It evaluates one of two ratiometric formulas, both normalised by 4096, the full-scale count of a 12-bit code.

The caller presents the operands and pulses `start`. The block samples every operand on that edge and ignores later changes. It forms the numerator with full-width multiplies and drops the low 12 bits. A restoring divider then produces one quotient bit per clock. The result and an invalid-input flag appear together with a one-cycle `done` pulse, and they hold until the next operation completes. A Z1 reading of zero cannot be divided by and is reported at once through the flag. A formula whose subtraction would go negative gives zero.

Top module: `touch_res_calc`

## Requirements
- R1: After reset, `busy`, `done` and `z1_err` are 0 and `res` is 0.
- R2: With `method` = 0 and Z2 > Z1 > 0, `res` = floor( floor(Rx·X·(Z2−Z1) / 4096) / Z1 ), and `z1_err` = 0.
- R3: With `method` = 0 and 0 < Z2 ≤ Z1 (the ratio term is zero or negative), `res` = 0 and `z1_err` = 0.
- R4: With `method` = 1 and Z1 > 0, A = floor( floor(Rx·X·(4096−Z1) / 4096) / Z1 ) and B = floor(Ry·(4096−Y) / 4096). `res` is A−B when A > B and 0 otherwise, and `z1_err` = 0.
- R5: With Z1 = 0, under either method, `res` has every bit set (all RW+12 bits) and `z1_err` = 1.
- R6: Call the clock edge on which `start` is accepted the accepting edge. When Z1 > 0, `done` rises after the (RW+12+2)th rising edge that follows it. When Z1 = 0, it rises after the first such edge. `busy` is high from the accepting edge until the cycle in which `done` is high, and it falls in that cycle.
- R7: `done` is high for exactly one cycle. `res` and `z1_err` change only in a cycle in which `done` is high, and they hold afterwards.
- R8: `start` is ignored while `busy` is high. It neither alters the running result nor begins a second operation.
- R9: All operands are sampled on the accepting edge. Changes to them during the operation do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation; accepted only while idle |
| method | input | 1 | Formula select: 0 uses X, Z1, Z2; 1 uses X, Y, Z1 and both plates |
| x_code | input | CW (12) | X position code |
| y_code | input | CW (12) | Y position code |
| z1_code | input | CW (12) | First cross-panel code (divisor) |
| z2_code | input | CW (12) | Second cross-panel code |
| rx_ohm | input | RW (16) | X-plate resistance |
| ry_ohm | input | RW (16) | Y-plate resistance |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| z1_err | output | 1 | Last result came from a zero Z1 |
| res | output | RW+CW (28) | Contact resistance, unsigned |

## Verification
The checker watches, on every cycle, the control contract. `done` lasts a single cycle and follows a busy period. `busy` only falls together with `done`. The result register moves only on completion. An error flag always comes with the saturated result. The arithmetic content cannot be seen by such properties. The exact quotient of each formula, the clamping of negative terms to zero, the exact latency, and the immunity to late `start` pulses and to operand changes are shown only by the bench's sweeps over Z1 and its scattered operand sets. The bench computes each expected value from the formulas.

// File: rtl/tpr_pkg.sv
// Shared types for the touch contact resistance calculator.
package tpr_pkg;

    // Controller phases: waiting, forming the numerator, dividing.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PREP = 2'd1,
        ST_DIV  = 2'd2
    } tpr_state_e;

    // Formula selector as presented on the method pin.
    typedef enum logic {
        FORM_CROSS = 1'b0,  // X, Z1, Z2 and X plate
        FORM_PLATE = 1'b1   // X, Y, Z1 and both plates
    } tpr_form_e;

endpackage

// File: rtl/tpr_numer.sv
// Numerator and offset former.
// Forms the dividend floor(Rx*X*k / 2^CW) and the offset floor(Ry*(2^CW-Y) / 2^CW).
// The factor k is (Z2-Z1) for the cross formula, or 0 when Z2 <= Z1; it is (2^CW - Z1) for the plate formula.
// Assumes Z1 > 0 whenever the outputs are used; the controller screens Z1 = 0.
module tpr_numer
    import tpr_pkg::*;
#(
    parameter int RW = 16,
    parameter int CW = 12
) (
    input  tpr_form_e        form,
    input  logic [CW-1:0]    x,
    input  logic [CW-1:0]    y,
    input  logic [CW-1:0]    z1,
    input  logic [CW-1:0]    z2,
    input  logic [RW-1:0]    rx,
    input  logic [RW-1:0]    ry,
    output logic [RW+CW-1:0] dividend,
    output logic [RW:0]      offset
);
    localparam int DW = RW + CW;
    localparam int PW = RW + 2*CW + 1;
    localparam int OW = RW + CW + 1;
    localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};

    logic [CW:0]   fac;
    logic [PW-1:0] prod;
    logic [OW-1:0] oprod;

    // Pick the ratio factor and build both full-width products before the shift.
    always_comb begin
        if (form == FORM_PLATE) begin
            fac = FULL - {1'b0, z1};
        end else if (z2 > z1) begin
            fac = {1'b0, z2 - z1};
        end else begin
            fac = '0;
        end
        prod     = PW'(rx) * PW'(x) * PW'(fac);
        dividend = DW'(prod >> CW);
        oprod    = OW'(ry) * OW'(FULL - {1'b0, y});
        offset   = (form == FORM_PLATE) ? (RW+1)'(oprod >> CW) : '0;
    end

endmodule

// File: rtl/tpr_divider.sv
// Restoring divider, one quotient bit per clock.
// load captures the operands.
// finish is high for one cycle, NW+1 cycles after the load edge; quot is valid while it is high.
// Assumes denom is nonzero.
module tpr_divider #(
    parameter int NW = 28,
    parameter int VW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [NW-1:0] numer,
    input  logic [VW-1:0] denom,
    output logic          finish,
    output logic [NW-1:0] quot
);
    localparam int CNTW = $clog2(NW + 1);
    localparam logic [CNTW-1:0] CNT_INIT = CNTW'(NW);

    logic [VW-1:0]   rem;
    logic [VW-1:0]   den;
    logic [NW-1:0]   quo;
    logic [CNTW-1:0] cnt;
    logic            run;
    logic [VW:0]     shl;
    logic            take;
    logic [VW-1:0]   nxt_rem;

    // Trial subtraction of the divisor from the shifted partial remainder.
    always_comb begin
        shl     = {rem, quo[NW-1]};
        take    = (shl >= {1'b0, den});
        nxt_rem = VW'(take ? (shl - {1'b0, den}) : shl);
    end

    // Iteration registers: load, shift one bit per cycle, then retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
            den <= '0;
            quo <= '0;
            cnt <= '0;
            run <= 1'b0;
        end else if (load) begin
            rem <= '0;
            den <= denom;
            quo <= numer;
            cnt <= CNT_INIT;
            run <= 1'b1;
        end else if (run) begin
            if (cnt != '0) begin
                quo <= {quo[NW-2:0], take};
                rem <= nxt_rem;
                cnt <= cnt - 1'b1;
            end else begin
                run <= 1'b0;
            end
        end
    end

    assign finish = run && (cnt == '0);
    assign quot   = quo;

endmodule

// File: rtl/tpr_settle.sv
// Final combine: passes the quotient through for the cross formula.
// For the plate formula it subtracts the offset and clamps negative values to zero.
module tpr_settle
    import tpr_pkg::*;
#(
    parameter int RW = 16,
    parameter int CW = 12
) (
    input  tpr_form_e        form,
    input  logic [RW+CW-1:0] quot,
    input  logic [RW:0]      offset,
    output logic [RW+CW-1:0] value
);
    localparam int DW = RW + CW;

    logic [DW-1:0] off_w;

    // Saturating subtraction for the plate formula.
    always_comb begin
        off_w = DW'(offset);
        if (form == FORM_PLATE) begin
            value = (quot > off_w) ? (quot - off_w) : '0;
        end else begin
            value = quot;
        end
    end

endmodule

// File: rtl/touch_res_calc.sv
// Touch contact resistance calculator, top level.
// Samples the operands on an accepted start and screens Z1 = 0 in the cycle after.
// It then runs the divider and posts the result with a one-cycle done pulse.
// The result and the error flag hold until the next completion.
// Assumes CW >= 2 and RW >= 1.
module touch_res_calc
    import tpr_pkg::*;
#(
    parameter int RW = 16,
    parameter int CW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             method,
    input  logic [CW-1:0]    x_code,
    input  logic [CW-1:0]    y_code,
    input  logic [CW-1:0]    z1_code,
    input  logic [CW-1:0]    z2_code,
    input  logic [RW-1:0]    rx_ohm,
    input  logic [RW-1:0]    ry_ohm,
    output logic             busy,
    output logic             done,
    output logic             z1_err,
    output logic [RW+CW-1:0] res
);
    localparam int DW = RW + CW;

    tpr_state_e      st;
    tpr_form_e       form_r;
    logic [CW-1:0]   x_r, y_r, z1_r, z2_r;
    logic [RW-1:0]   rx_r, ry_r;
    logic [RW:0]     off_r;
    logic [DW-1:0]   res_r;
    logic            err_r;
    logic            done_r;

    logic [DW-1:0]   dividend;
    logic [RW:0]     offset;
    logic            div_load;
    logic            div_fin;
    logic [DW-1:0]   quot;
    logic [DW-1:0]   settled;

    tpr_numer #(.RW(RW), .CW(CW)) u_numer (
        .form     (form_r),
        .x        (x_r),
        .y        (y_r),
        .z1       (z1_r),
        .z2       (z2_r),
        .rx       (rx_r),
        .ry       (ry_r),
        .dividend (dividend),
        .offset   (offset)
    );

    assign div_load = (st == ST_PREP) && (z1_r != '0);

    tpr_divider #(.NW(DW), .VW(CW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (div_load),
        .numer  (dividend),
        .denom  (z1_r),
        .finish (div_fin),
        .quot   (quot)
    );

    tpr_settle #(.RW(RW), .CW(CW)) u_settle (
        .form   (form_r),
        .quot   (quot),
        .offset (off_r),
        .value  (settled)
    );

    // Sequencing: capture operands, screen Z1, wait for the divider, post the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            form_r <= FORM_CROSS;
            x_r    <= '0;
            y_r    <= '0;
            z1_r   <= '0;
            z2_r   <= '0;
            rx_r   <= '0;
            ry_r   <= '0;
            off_r  <= '0;
            res_r  <= '0;
            err_r  <= 1'b0;
            done_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        form_r <= tpr_form_e'(method);
                        x_r    <= x_code;
                        y_r    <= y_code;
                        z1_r   <= z1_code;
                        z2_r   <= z2_code;
                        rx_r   <= rx_ohm;
                        ry_r   <= ry_ohm;
                        st     <= ST_PREP;
                    end
                end
                ST_PREP: begin
                    if (z1_r == '0) begin
                        res_r  <= '1;
                        err_r  <= 1'b1;
                        done_r <= 1'b1;
                        st     <= ST_IDLE;
                    end else begin
                        off_r  <= offset;
                        st     <= ST_DIV;
                    end
                end
                ST_DIV: begin
                    if (div_fin) begin
                        res_r  <= settled;
                        err_r  <= 1'b0;
                        done_r <= 1'b1;
                        st     <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy   = (st != ST_IDLE);
    assign done   = done_r;
    assign z1_err = err_r;
    assign res    = res_r;

endmodule

// File: rtl/touch_res_calc_chk.sv
// Protocol checker for touch_res_calc, attached by bind.
// It observes ports only.
module touch_res_calc_chk #(
    parameter int RW = 16,
    parameter int CW = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             z1_err,
    input logic [RW+CW-1:0] res
);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R6
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(res) || !$stable(z1_err)) |-> done);

    // R5
    err_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        z1_err |-> (res == '1));

endmodule

bind touch_res_calc touch_res_calc_chk #(.RW(RW), .CW(CW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .z1_err (z1_err),
    .res    (res)
);

// File: tb/touch_res_calc_test.sv
`timescale 1ns/1ps
// Bench for touch_res_calc in a reduced configuration (RW = 8).
// It sweeps Z1 across its whole range and adds scattered and directed operand sets.
module touch_res_calc_test;
    localparam int RW  = 8;
    localparam int CW  = 12;
    localparam int DW  = RW + CW;
    localparam int LAT = DW + 2;
    localparam longint unsigned ALL1 = (64'd1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          method = 1'b0;
    logic [CW-1:0] x_code = '0, y_code = '0, z1_code = '0, z2_code = '0;
    logic [RW-1:0] rx_ohm = '0, ry_ohm = '0;
    logic          busy, done, z1_err;
    logic [DW-1:0] res;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    touch_res_calc #(.RW(RW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .method(method),
        .x_code(x_code), .y_code(y_code), .z1_code(z1_code), .z2_code(z2_code),
        .rx_ohm(rx_ohm), .ry_ohm(ry_ohm),
        .busy(busy), .done(done), .z1_err(z1_err), .res(res)
    );

    task automatic chk(input string tag, input longint unsigned act, input longint unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected result from the formulas of R2, R3, R4 and R5.
    function automatic longint unsigned model(input bit m, input longint unsigned x, y, z1, z2, rx, ry);
        longint unsigned a, b;
        if (z1 == 0) return ALL1;
        if (!m) begin
            if (z2 <= z1) return 0;
            return ((rx * x * (z2 - z1)) >> 12) / z1;
        end
        a = ((rx * x * (4096 - z1)) >> 12) / z1;
        b = (ry * (4096 - y)) >> 12;
        return (a > b) ? a - b : 0;
    endfunction

    // One operation. Operands are scrambled after acceptance (R9).
    // When poke is set, a second start is pulsed mid-run (R8).
    task automatic run_op(input string tag, input bit m, input int x, y, z1, z2, rx, ry, input bit poke);
        longint unsigned exp_v;
        int n;
        exp_v = model(m, x, y, z1, z2, rx, ry);
        @(negedge clk);
        method = m; x_code = CW'(x); y_code = CW'(y); z1_code = CW'(z1); z2_code = CW'(z2);
        rx_ohm = RW'(rx); ry_ohm = RW'(ry); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        method = ~m; x_code = ~x_code; y_code = ~y_code; z1_code = CW'(z1 + 5);
        z2_code = ~z2_code; rx_ohm = ~rx_ohm; ry_ohm = ~ry_ohm;
        n = 0;
        while (1) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            start = (poke && n == 3);
            if (done) break;
            if (n > 2 * LAT + 10) begin
                chk("R6 watchdog", n, LAT);
                start = 1'b0;
                return;
            end
        end
        start = 1'b0;
        chk({tag, " result"}, res, exp_v);
        chk({tag, " z1_err"}, z1_err, (z1 == 0));
        chk("R6 latency", n, (z1 == 0) ? 1 : LAT);
        @(negedge clk);
        chk("R7 done width", done, 0);
        chk("R8 idle after done", busy, 0);
        chk("R7 result held", res, exp_v);
    endtask

    initial begin
        #(200000 * 20);
        n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 z1_err", z1_err, 0);
        chk("R1 res", res, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 res after release", res, 0);

        // R2 cross formula, directed
        run_op("R2", 0, 2048, 0, 1000, 3000, 200, 0, 0);
        run_op("R2", 0, 4095, 0, 1, 4095, 255, 0, 0);
        // R3 ratio term zero or negative
        run_op("R3", 0, 3000, 0, 2500, 1200, 250, 0, 0);
        run_op("R3", 0, 3000, 0, 1700, 1700, 250, 0, 0);
        // R4 plate formula, positive and clamped
        run_op("R4", 1, 3000, 1000, 500, 0, 250, 100, 0);
        run_op("R4", 1, 10, 0, 4000, 0, 20, 255, 0);
        run_op("R4", 1, 4095, 4095, 1, 0, 255, 255, 0);
        // R5 zero Z1 under both formulas
        run_op("R5", 0, 1234, 0, 0, 4000, 99, 0, 0);
        run_op("R5", 1, 1234, 321, 0, 0, 99, 77, 0);
        // R8 start pulsed during the run
        run_op("R8", 0, 1500, 0, 800, 3900, 180, 0, 1);
        run_op("R8", 1, 3500, 200, 300, 0, 240, 60, 1);

        // R2 R3 R4 R5 sweep over every Z1 value with stride 3 (including 0)
        for (int z = 0; z < 4096; z += 3) begin
            run_op((z % 2) ? "R4" : "R2", z % 2, 4095 - z, (z * 5) % 4096, z,
                   (z * 7 + 11) % 4096, 255 - (z % 200), z % 256, 0);
        end

        // R2 R4 R9 scattered operand sets
        for (int i = 0; i < 1500; i++) begin
            int m, xv, yv, z1v, z2v, rxv, ryv;
            m   = $urandom % 2;
            xv  = $urandom % 4096;
            yv  = $urandom % 4096;
            z1v = 1 + $urandom % 4095;
            z2v = $urandom % 4096;
            rxv = $urandom % 256;
            ryv = $urandom % 256;
            run_op(m ? "R4 R9" : "R2 R9", m[0], xv, yv, z1v, z2v, rxv, ryv, (i % 7) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule